// File: doc/BRIEF.md
# Spare-Swap Diagnosis Controller

This block finds and repairs a faulty partition after the surrounding checkers have flagged an error. The datapath it serves is split into a set of partitions. Each partition has a primary copy and a fixed number of spare copies, and only one copy of each partition is active at a time. The controller drives one copy-select field per partition. It finds the fault by trial and error. First it asks the system to roll back to its last known-good state. Then it moves one partition onto its next spare and asks the system to restart. After that it watches the error line for a programmable number of cycles.

If the error comes back inside that window, the swap is kept and the search moves on to the next partition. A clean window means the repair worked: the controller goes back to idle and the next error event starts again from partition 0. A partition whose last spare is already in use is skipped. The controller raises a sticky fatal flag in two cases: the error comes back while the highest-index partition is under trial, or no partition at or above the current index has a spare left. The rollback and restart mechanisms report completion through acknowledge inputs.

Top module: `spare_swap_diag`

## Requirements
- R1: While reset is held and immediately after it, every select field is 0 (primary copy), both request outputs are low and the fatal flag is low.
- R2: An error seen while idle raises `rollback_req_o` for exactly one cycle, in the cycle after the error. The controller then waits for `rollback_ack_i`, which is counted only after the pulse.
- R3: The controller searches after the rollback acknowledge. In the cycle after the acknowledge it looks for the lowest-index partition, at or above the current index, that still has a spare. One cycle later that partition's select field goes up by one, and `restart_req_o` pulses high in that same cycle.
- R4: `restart_req_o` is high for exactly one cycle and never together with `rollback_req_o`. The controller then waits for `restart_ack_i`. The observation window starts in the cycle after the acknowledge is sampled.
- R5: If `err_i` stays low for `win_len_i` cycles of the window, the repair is kept and the controller goes back to idle. A window length of 0 counts as 1. The next error event then starts its search again at partition 0.
- R6: An error during the window leaves the swapped select field unchanged and advances the index by one. It is followed in the next cycle by a new rollback pulse, unless the index was already at the last partition.
- R7: A partition whose select field already equals the spare count is skipped by the search.
- R8: `err_i` is ignored while the controller waits for either acknowledge: no extra request pulse and no select change.
- R9: `fatal_o` goes high in two cases. It rises in the cycle after an error hits a window whose trial partition is the last one. It also rises in the cycle after the search finds no partition with a spare. Once high, it stays high until reset, and errors then cause no request and no select change.
- R10: Field p of `sel_o` occupies bits [p*SEL_W +: SEL_W]. It holds the index of the active copy: 0 is the primary and 1..NUM_SPARES are the spares. It never exceeds NUM_SPARES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_i | input | 1 | Error detected by the surrounding checkers |
| win_len_i | input | WIN_W | Observation window length in cycles (0 counts as 1) |
| rollback_req_o | output | 1 | One-cycle request to roll back to the last good state |
| rollback_ack_i | input | 1 | Rollback finished |
| restart_req_o | output | 1 | One-cycle request to resume execution |
| restart_ack_i | input | 1 | Execution resumed |
| sel_o | output | NUM_PARTS*SEL_W | Active-copy index for each partition |
| fatal_o | output | 1 | Sticky unrecoverable-defect flag |

## Verification
A wrong index or a corrupted select field shows up at the next restart pulse. At that point the wrong field moves, or a field that should have been skipped moves, and the bench compares the whole select vector in exactly that cycle. A wrong state or window count appears one cycle after the decisive error. In that cycle the bench sees a rollback pulse that should not be there, a missing one, or an early or late fatal flag. Bench scenarios are chosen so that a failed trial and a fresh error event pick different partitions. That way, an off-by-one in the window length changes which select field moves.

// File: rtl/sswap_pkg.sv
package sswap_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RB_REQ,
      ST_RB_WAIT,
      ST_SEEK,
      ST_RS_REQ,
      ST_RS_WAIT,
      ST_WATCH,
      ST_DEAD
   } diag_state_t;

   // bits needed to hold the values 0 .. n-1
   function automatic int unsigned width_of(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sswap_sel_bank.sv
module sswap_sel_bank #(
   parameter int unsigned NUM_PARTS  = 4,
   parameter int unsigned NUM_SPARES = 1,
   parameter int unsigned SEL_W      = 1,
   parameter int unsigned IDX_W      = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bump_i,
   input  logic [IDX_W-1:0]           bump_idx_i,
   output logic [NUM_PARTS*SEL_W-1:0] sel_o,
   output logic [NUM_PARTS-1:0]       avail_o
);

   localparam logic [SEL_W-1:0] LAST_COPY = SEL_W'(NUM_SPARES);

   for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part
      logic hit;
      assign hit = bump_i && (bump_idx_i == IDX_W'(p));

      if (NUM_SPARES == 1) begin : g_flag
         // single spare: one flop tells primary from spare
         logic spare_q;
         always_ff @(posedge clk) begin
            if (!rst_n)   spare_q <= 1'b0;
            else if (hit) spare_q <= 1'b1;
         end
         assign sel_o[p*SEL_W +: SEL_W] = SEL_W'(spare_q);
         assign avail_o[p]              = !spare_q;
      end else begin : g_count
         logic [SEL_W-1:0] copy_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               copy_q <= '0;
            else if (hit && (copy_q != LAST_COPY))
               copy_q <= copy_q + SEL_W'(1);
         end
         assign sel_o[p*SEL_W +: SEL_W] = copy_q;
         assign avail_o[p]              = (copy_q != LAST_COPY);
      end
   end

endmodule

// File: rtl/sswap_seeker.sv
module sswap_seeker #(
   parameter int unsigned NUM_PARTS = 4,
   parameter int unsigned IDX_W     = 2
) (
   input  logic [IDX_W-1:0]     from_i,
   input  logic [NUM_PARTS-1:0] avail_i,
   output logic                 hit_o,
   output logic [IDX_W-1:0]     hit_idx_o
);

   // lowest partition at or above from_i that still owns a spare
   always_comb begin
      hit_o     = 1'b0;
      hit_idx_o = '0;
      for (int k = NUM_PARTS - 1; k >= 0; k--) begin
         if (avail_i[k] && (k >= int'(from_i))) begin
            hit_o     = 1'b1;
            hit_idx_o = IDX_W'(k);
         end
      end
   end

endmodule

// File: rtl/sswap_window.sv
module sswap_window #(
   parameter int unsigned WIN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic [WIN_W-1:0] len_i,
   output logic             expired_o
);

   localparam int unsigned CW = WIN_W + 1;

   logic [WIN_W-1:0] cnt_q;
   logic [CW-1:0]    next_c;

   assign next_c    = {1'b0, cnt_q} + CW'(1);
   // a zero length behaves like one cycle
   assign expired_o = (next_c >= {1'b0, len_i});

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) cnt_q <= '0;
      else if (!expired_o)   cnt_q <= cnt_q + WIN_W'(1);
   end

endmodule

// File: rtl/spare_swap_diag.sv
module spare_swap_diag
   import sswap_pkg::*;
#(
   parameter  int unsigned NUM_PARTS  = 4,
   parameter  int unsigned NUM_SPARES = 1,
   parameter  int unsigned WIN_W      = 8,
   localparam int unsigned SEL_W      = width_of(NUM_SPARES + 1),
   localparam int unsigned IDX_W      = width_of(NUM_PARTS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       err_i,
   input  logic [WIN_W-1:0]           win_len_i,
   output logic                       rollback_req_o,
   input  logic                       rollback_ack_i,
   output logic                       restart_req_o,
   input  logic                       restart_ack_i,
   output logic [NUM_PARTS*SEL_W-1:0] sel_o,
   output logic                       fatal_o
);

   if (NUM_PARTS < 1) begin : g_bad_parts
      $error("spare_swap_diag: NUM_PARTS must be at least 1");
   end
   if (NUM_SPARES < 1) begin : g_bad_spares
      $error("spare_swap_diag: NUM_SPARES must be at least 1");
   end
   if (WIN_W < 1) begin : g_bad_win
      $error("spare_swap_diag: WIN_W must be at least 1");
   end
   if ((1 << SEL_W) <= NUM_SPARES) begin : g_bad_sel
      $error("spare_swap_diag: SEL_W too narrow for NUM_SPARES");
   end

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PARTS - 1);

   diag_state_t          state_q, state_d;
   logic [IDX_W-1:0]     idx_q, idx_d;
   logic                 bump;
   logic                 hit;
   logic [IDX_W-1:0]     hit_idx;
   logic [NUM_PARTS-1:0] avail;
   logic                 win_done;

   sswap_sel_bank #(
      .NUM_PARTS (NUM_PARTS),
      .NUM_SPARES(NUM_SPARES),
      .SEL_W     (SEL_W),
      .IDX_W     (IDX_W)
   ) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bump_i    (bump),
      .bump_idx_i(hit_idx),
      .sel_o     (sel_o),
      .avail_o   (avail)
   );

   sswap_seeker #(
      .NUM_PARTS(NUM_PARTS),
      .IDX_W    (IDX_W)
   ) seek_i (
      .from_i   (idx_q),
      .avail_i  (avail),
      .hit_o    (hit),
      .hit_idx_o(hit_idx)
   );

   sswap_window #(
      .WIN_W(WIN_W)
   ) win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (state_q != ST_WATCH),
      .len_i    (win_len_i),
      .expired_o(win_done)
   );

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      bump    = 1'b0;
      unique case (state_q)
         ST_IDLE:    if (err_i) state_d = ST_RB_REQ;
         ST_RB_REQ:  state_d = ST_RB_WAIT;
         ST_RB_WAIT: if (rollback_ack_i) state_d = ST_SEEK;
         ST_SEEK: begin
            if (hit) begin
               idx_d   = hit_idx;
               bump    = 1'b1;
               state_d = ST_RS_REQ;
            end else begin
               state_d = ST_DEAD;
            end
         end
         ST_RS_REQ:  state_d = ST_RS_WAIT;
         ST_RS_WAIT: if (restart_ack_i) state_d = ST_WATCH;
         ST_WATCH: begin
            if (err_i) begin
               if (idx_q == LAST_IDX) begin
                  state_d = ST_DEAD;
               end else begin
                  idx_d   = idx_q + IDX_W'(1);
                  state_d = ST_RB_REQ;
               end
            end else if (win_done) begin
               idx_d   = '0;
               state_d = ST_IDLE;
            end
         end
         ST_DEAD:    state_d = ST_DEAD;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end

   assign rollback_req_o = (state_q == ST_RB_REQ);
   assign restart_req_o  = (state_q == ST_RS_REQ);
   assign fatal_o        = (state_q == ST_DEAD);

endmodule

// File: rtl/sswap_checker.sv
module sswap_checker
   import sswap_pkg::*;
#(
   parameter int unsigned NUM_PARTS  = 4,
   parameter int unsigned NUM_SPARES = 1,
   parameter int unsigned SEL_W      = 1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       err_i,
   input logic                       rollback_req_o,
   input logic                       restart_req_o,
   input logic                       fatal_o,
   input logic [NUM_PARTS*SEL_W-1:0] sel_o,
   input diag_state_t                state_q
);

   assert_rb_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_req_o |=> !rollback_req_o);

   assert_rb_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rollback_req_o |-> $past(err_i));

   assert_rs_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req_o |=> !restart_req_o);

   assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(rollback_req_o && restart_req_o));

   // select fields move only together with a restart pulse
   assert_sel_moves_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sel_o) |-> restart_req_o);

   assert_rs_after_seek_R3: assert property (@(posedge clk) disable iff (!rst_n)
      restart_req_o |-> $past(state_q) == ST_SEEK);

   assert_fatal_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |=> fatal_o);

   assert_fatal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fatal_o |-> (!rollback_req_o && !restart_req_o && $stable(sel_o)));

   for (genvar p = 0; p < NUM_PARTS; p++) begin : g_rng
      assert_sel_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
         sel_o[p*SEL_W +: SEL_W] <= SEL_W'(NUM_SPARES));
   end

endmodule

bind spare_swap_diag sswap_checker #(
   .NUM_PARTS (NUM_PARTS),
   .NUM_SPARES(NUM_SPARES),
   .SEL_W     (SEL_W)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .err_i         (err_i),
   .rollback_req_o(rollback_req_o),
   .restart_req_o (restart_req_o),
   .fatal_o       (fatal_o),
   .sel_o         (sel_o),
   .state_q       (state_q)
);

// File: tb/spare_swap_diag_tb_top.sv
module spare_swap_diag_tb_top;

   localparam int NP = 3;
   localparam int NS = 2;
   localparam int SW = 2;   // bits for copy indices 0..2
   localparam int WW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          err_i = 1'b0;
   logic [WW-1:0] win_len = '0;
   logic          rb_ack = 1'b0;
   logic          rs_ack = 1'b0;
   logic          rb_req, rs_req, fatal;
   logic [NP*SW-1:0] sel;

   int n_chk = 0;
   int n_err = 0;
   int m_sel [NP];
   int m_idx = 0;
   bit m_fatal = 1'b0;
   int w_eff = 1;

   always #10 clk = ~clk;   // 50 MHz

   spare_swap_diag #(
      .NUM_PARTS (NP),
      .NUM_SPARES(NS),
      .WIN_W     (WW)
   ) dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .err_i         (err_i),
      .win_len_i     (win_len),
      .rollback_req_o(rb_req),
      .rollback_ack_i(rb_ack),
      .restart_req_o (rs_req),
      .restart_ack_i (rs_ack),
      .sel_o         (sel),
      .fatal_o       (fatal)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_sel();
      int v = 0;
      for (int p = 0; p < NP; p++) v |= m_sel[p] << (p * SW);
      return v;
   endfunction

   task automatic do_reset(input int wlen);
      rst_n = 1'b0; err_i = 1'b0; rb_ack = 1'b0; rs_ack = 1'b0;
      win_len = WW'(wlen);
      w_eff = (wlen == 0) ? 1 : wlen;
      for (int p = 0; p < NP; p++) m_sel[p] = 0;
      m_idx = 0; m_fatal = 1'b0;
      repeat (3) @(negedge clk);
      chk(sel == 0 && !rb_req && !rs_req && !fatal, "R1 during reset", int'(sel), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sel == 0 && !rb_req && !rs_req && !fatal, "R1 after reset", int'(sel), 0);
   endtask

   // at a negedge in idle: raise one error and check the response
   task automatic begin_event();
      err_i = 1'b1;
      @(negedge clk);
      err_i = 1'b0;
      if (m_fatal) begin
         chk(!rb_req && fatal, "R9 error ignored when fatal", int'(rb_req), 0);
         chk(int'(sel) == exp_sel(), "R9 sel frozen", int'(sel), exp_sel());
      end else begin
         chk(rb_req, "R2 rollback pulse after error", int'(rb_req), 1);
      end
   endtask

   // entered at the negedge where the rollback pulse is visible
   task automatic seek_restart();
      int hit = -1;
      @(negedge clk);
      chk(!rb_req, "R2 rollback is one cycle", int'(rb_req), 0);
      err_i = 1'b1;
      @(negedge clk);
      err_i = 1'b0;
      chk(!rb_req && !rs_req, "R8 error ignored in rollback wait", int'(rb_req), 0);
      rb_ack = 1'b1;
      @(negedge clk);
      rb_ack = 1'b0;
      chk(!rs_req && int'(sel) == exp_sel(), "R3 no restart during search", int'(rs_req), 0);
      @(negedge clk);
      for (int p = NP - 1; p >= m_idx; p--) if (m_sel[p] < NS) hit = p;
      if (hit < 0) begin
         m_fatal = 1'b1;
         chk(fatal && !rs_req, "R9 fatal when no spare left", int'(fatal), 1);
         chk(int'(sel) == exp_sel(), "R7 sel unchanged at exhaustion", int'(sel), exp_sel());
         return;
      end
      m_sel[hit]++;
      m_idx = hit;
      chk(rs_req, "R3 restart pulse after search", int'(rs_req), 1);
      chk(int'(sel) == exp_sel(), "R3 R7 R10 spare swapped in", int'(sel), exp_sel());
      @(negedge clk);
      chk(!rs_req, "R4 restart is one cycle", int'(rs_req), 0);
      err_i = 1'b1;
      @(negedge clk);
      err_i = 1'b0;
      chk(!rb_req && !rs_req && int'(sel) == exp_sel(), "R8 error ignored in restart wait",
          int'(rb_req), 0);
      rs_ack = 1'b1;
      @(negedge clk);
      rs_ack = 1'b0;
   endtask

   // entered at the negedge of the first window cycle; e<0 means no error
   task automatic watch(input int e);
      if (e < 0) begin
         for (int c = 0; c < w_eff; c++) begin
            chk(!rb_req && !rs_req && !fatal, "R5 quiet window", int'(rb_req), 0);
            @(negedge clk);
         end
         m_idx = 0;
         chk(!rb_req && !fatal && int'(sel) == exp_sel(), "R5 repair kept", int'(sel), exp_sel());
         return;
      end
      for (int c = 0; c < e; c++) begin
         chk(!rb_req && !rs_req && !fatal, "R4 window before error", int'(rb_req), 0);
         @(negedge clk);
      end
      err_i = 1'b1;
      @(negedge clk);
      err_i = 1'b0;
      if (e < w_eff) begin
         if (m_idx == NP - 1) begin
            m_fatal = 1'b1;
            chk(fatal && !rb_req, "R9 fatal at last partition", int'(fatal), 1);
         end else begin
            m_idx++;
            chk(rb_req && !fatal, "R6 retry after error in window", int'(rb_req), 1);
         end
      end else begin
         m_idx = 0;
         chk(rb_req && !fatal, "R5 error after window is new event", int'(rb_req), 1);
      end
      chk(int'(sel) == exp_sel(), "R6 swap not undone", int'(sel), exp_sel());
   endtask

   task automatic dead_poke();
      for (int k = 0; k < 3; k++) begin
         begin_event();
         @(negedge clk);
         chk(fatal && !rb_req && !rs_req, "R9 fatal sticky", int'(fatal), 1);
      end
   endtask

   initial begin
      // window of 3 cycles
      do_reset(3);
      begin_event(); seek_restart(); watch(-1);          // p0 -> 1
      begin_event(); seek_restart(); watch(1);           // p0 -> 2, fails
      seek_restart(); watch(2);                          // p1 -> 1, fails at last window cycle
      seek_restart(); watch(3);                          // p2 -> 1, ok; error right after window
      seek_restart(); watch(-1);                         // from 0: p0 skipped, p1 -> 2
      begin_event(); seek_restart(); watch(0);           // p2 -> 2, fails at last partition
      dead_poke();

      // zero length acts as one cycle
      do_reset(0);
      begin_event(); seek_restart(); watch(1);           // p0 -> 1 ok, new event
      seek_restart(); watch(0);                          // p0 -> 2 fails
      seek_restart(); watch(-1);                         // p1 -> 1

      // exhaust every spare with clean windows, then fail to find one
      do_reset(1);
      for (int k = 0; k < NP * NS + 1; k++) begin
         begin_event();
         seek_restart();
         if (m_fatal) break;
         watch(-1);
      end
      chk(m_fatal, "R7 R9 exhaustion reached", int'(m_fatal), 1);
      dead_poke();

      // a reset clears a fatal controller
      do_reset(2);
      begin_event(); seek_restart(); watch(-1);

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule